// File: doc/BRIEF.md
# Compressed Cache Store-Update Unit

This unit applies one 32-bit processor store to a single word of a line held in a frequent-value compressed data cache. In that cache each word of a line has a small descriptor in the tag entry. The descriptor either names a dictionary entry that holds the word's value (the word then uses no data-array storage), or names the word position inside the shared data slot where the raw value lives. The unit takes the hit word's descriptor, the slot's word occupancy map, the current stored value, the store data with byte enables, and the dictionary contents. It works out the word's new descriptor, an optional data-array write, the new occupancy map, and whether the slot ran out of room.

A compressed word may become uncompressed when a store gives it a value that is not in the dictionary. The reverse never happens. A raw word stays raw even when the new value could be encoded, which keeps the write path small. Partial stores are merged with the word's current value before the dictionary lookup. Every accepted store produces registered results, with a one-cycle done pulse, on the next clock edge.

Top module: `cc_store_update`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `st_valid` high, and low otherwise. `dwr_en` and `ovf` are never high while `done` is low.
- R2: Descriptor format: bit MASK_W-1 is the status (1 = encoded, 0 = raw) and the low bits are the dictionary index or the slot word offset. When the word is encoded and the merged value equals a dictionary entry, `mask_out` becomes status 1 with the lowest matching index. There is no data-array write and `occ_out` equals `occ_in`.
- R3: When the word is encoded, the merged value matches no entry and `occ_in` has a clear bit (bit k = slot word k in use), the unit picks the lowest clear bit k. It writes the merged value at offset k, gives `mask_out` status 0 with offset k, and sets bit k in `occ_out`.
- R4: When the word is encoded, the merged value matches no entry and every occupancy bit is set, `ovf` is raised. There is no write, and `mask_out`/`occ_out` equal `mask_in`/`occ_in`.
- R5: When the word is raw, the merged value is written at the descriptor's offset, and `mask_out`/`occ_out` equal `mask_in`/`occ_in`.
- R6: A raw word whose merged value is in the dictionary is still written to the data array and keeps status 0.
- R7: Byte lane i of the merged value (bits 8i+7..8i) comes from `st_data` when `st_be[i]` is 1. Otherwise it comes from the current value: the indexed dictionary entry for an encoded word, or `slot_word` for a raw one.
- R8: After reset, `done`, `ovf`, `dwr_en`, `mask_out` and `occ_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store present this cycle |
| st_data | input | WORD_W | Store data |
| st_be | input | WORD_W/8 | Byte enables of the store |
| mask_in | input | MASK_W | Current descriptor of the target word |
| occ_in | input | SLOT_WORDS | Current slot occupancy map |
| slot_word | input | WORD_W | Data-array word at the descriptor offset (raw words) |
| dict_flat | input | DICT_DEPTH*WORD_W | Dictionary contents, entry j at bits j*WORD_W upward |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Slot had no free word for a needed allocation |
| dwr_en | output | 1 | Data-array write request |
| dwr_off | output | OFF_W | Data-array word offset to write |
| dwr_data | output | WORD_W | Data to write |
| mask_out | output | MASK_W | Updated descriptor |
| occ_out | output | SLOT_WORDS | Updated occupancy map |

## Verification
The bench builds the unit with its defaults: 32-bit words, an eight-entry dictionary and an eight-word slot. With eight occupancy bits, random maps that are biased toward full fill up often enough to exercise the overflow path in many stores. The eight-entry dictionary is loaded with two equal entries, so the lowest-index choice on a repeated value can be observed. Random byte enables, together with store data that is half the time a dictionary value, produce merged values that land on both sides of the match test, for encoded and raw words alike.

// File: rtl/cc_su_pkg.sv
package cc_su_pkg;
  typedef enum logic [2:0] {
    SU_IDLE     = 3'd0,
    SU_REINDEX  = 3'd1,
    SU_ALLOC    = 3'd2,
    SU_INPLACE  = 3'd3,
    SU_OVERFLOW = 3'd4
  } su_act_e;
endpackage

// File: rtl/cc_su_merge.sv
module cc_su_merge #(
  parameter int WORD_W     = 32,
  parameter int DICT_DEPTH = 8,
  parameter int IDX_W      = 3
) (
  input  logic                         is_enc,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DICT_DEPTH*WORD_W-1:0] dict_flat,
  input  logic [WORD_W-1:0]            slot_word,
  input  logic [WORD_W-1:0]            st_data,
  input  logic [WORD_W/8-1:0]          st_be,
  output logic [WORD_W-1:0]            merged
);
  localparam int BE_W = WORD_W / 8;

  logic [WORD_W-1:0] dict_val;
  logic [WORD_W-1:0] cur_val;

  always_comb begin
    dict_val = '0;
    for (int j = 0; j < DICT_DEPTH; j++) begin
      if (idx == IDX_W'(j)) dict_val = dict_flat[j*WORD_W +: WORD_W];
    end
  end

  assign cur_val = is_enc ? dict_val : slot_word;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged[b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8] : cur_val[b*8 +: 8];
  end
endmodule

// File: rtl/cc_su_match.sv
module cc_su_match #(
  parameter int WORD_W     = 32,
  parameter int DICT_DEPTH = 8,
  parameter int IDX_W      = 3
) (
  input  logic [WORD_W-1:0]            value,
  input  logic [DICT_DEPTH*WORD_W-1:0] dict_flat,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  logic [DICT_DEPTH-1:0] eq;

  for (genvar j = 0; j < DICT_DEPTH; j++) begin : g_cmp
    assign eq[j] = (dict_flat[j*WORD_W +: WORD_W] == value);
  end

  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    hit_idx = '0;
    for (int j = DICT_DEPTH - 1; j >= 0; j--) begin
      if (eq[j]) hit_idx = IDX_W'(j);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/cc_su_alloc.sv
module cc_su_alloc #(
  parameter int SLOT_WORDS = 8,
  parameter int OFF_W      = 3
) (
  input  logic [SLOT_WORDS-1:0] occ,
  output logic                  free_any,
  output logic [OFF_W-1:0]      free_off,
  output logic [SLOT_WORDS-1:0] occ_taken
);
  logic [SLOT_WORDS-1:0] free_vec;
  logic [SLOT_WORDS-1:0] pick_vec;

  assign free_vec = ~occ;

  always_comb begin
    free_off = '0;
    pick_vec = '0;
    for (int k = SLOT_WORDS - 1; k >= 0; k--) begin
      if (free_vec[k]) begin
        free_off = OFF_W'(k);
        pick_vec = SLOT_WORDS'(1) << k;
      end
    end
  end

  assign free_any  = |free_vec;
  assign occ_taken = occ | pick_vec;
endmodule

// File: rtl/cc_store_update.sv
module cc_store_update #(
  parameter int WORD_W     = 32,
  parameter int DICT_DEPTH = 8,
  parameter int SLOT_WORDS = 8,
  localparam int IDX_W  = $clog2(DICT_DEPTH),
  localparam int OFF_W  = $clog2(SLOT_WORDS),
  localparam int META_W = (IDX_W > OFF_W) ? IDX_W : OFF_W,
  localparam int MASK_W = META_W + 1,
  localparam int BE_W   = WORD_W / 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_valid,
  input  logic [WORD_W-1:0]            st_data,
  input  logic [BE_W-1:0]              st_be,
  input  logic [MASK_W-1:0]            mask_in,
  input  logic [SLOT_WORDS-1:0]        occ_in,
  input  logic [WORD_W-1:0]            slot_word,
  input  logic [DICT_DEPTH*WORD_W-1:0] dict_flat,
  output logic                         done,
  output logic                         ovf,
  output logic                         dwr_en,
  output logic [OFF_W-1:0]             dwr_off,
  output logic [WORD_W-1:0]            dwr_data,
  output logic [MASK_W-1:0]            mask_out,
  output logic [SLOT_WORDS-1:0]        occ_out
);
  import cc_su_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_a, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a  <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs_a  <= 1'b1;
      rst_s <= rs_a;
    end
  end

  logic              is_enc;
  logic [IDX_W-1:0]  cur_idx;
  logic [OFF_W-1:0]  cur_off;
  logic [WORD_W-1:0] merged;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              free_any;
  logic [OFF_W-1:0]  free_off;
  logic [SLOT_WORDS-1:0] occ_taken;

  assign is_enc  = mask_in[MASK_W-1];
  assign cur_idx = mask_in[IDX_W-1:0];
  assign cur_off = mask_in[OFF_W-1:0];

  cc_su_merge #(.WORD_W(WORD_W), .DICT_DEPTH(DICT_DEPTH), .IDX_W(IDX_W)) u_merge (
    .is_enc(is_enc), .idx(cur_idx), .dict_flat(dict_flat), .slot_word(slot_word),
    .st_data(st_data), .st_be(st_be), .merged(merged)
  );

  cc_su_match #(.WORD_W(WORD_W), .DICT_DEPTH(DICT_DEPTH), .IDX_W(IDX_W)) u_match (
    .value(merged), .dict_flat(dict_flat), .hit(hit), .hit_idx(hit_idx)
  );

  cc_su_alloc #(.SLOT_WORDS(SLOT_WORDS), .OFF_W(OFF_W)) u_alloc (
    .occ(occ_in), .free_any(free_any), .free_off(free_off), .occ_taken(occ_taken)
  );

  // action decode
  su_act_e act;
  always_comb begin
    if (!st_valid)     act = SU_IDLE;
    else if (!is_enc)  act = SU_INPLACE;
    else if (hit)      act = SU_REINDEX;
    else if (free_any) act = SU_ALLOC;
    else               act = SU_OVERFLOW;
  end

  // next state
  logic                  done_q, ovf_q, wen_q;
  logic [OFF_W-1:0]      off_q;
  logic [WORD_W-1:0]     data_q;
  logic [MASK_W-1:0]     mask_q;
  logic [SLOT_WORDS-1:0] occ_q;

  logic                  done_d, ovf_d, wen_d;
  logic [OFF_W-1:0]      off_d;
  logic [WORD_W-1:0]     data_d;
  logic [MASK_W-1:0]     mask_d;
  logic [SLOT_WORDS-1:0] occ_d;
  logic                  upd_en;

  assign upd_en = st_valid;

  always_comb begin
    done_d = st_valid;
    ovf_d  = 1'b0;
    wen_d  = 1'b0;
    off_d  = cur_off;
    data_d = merged;
    mask_d = mask_in;
    occ_d  = occ_in;
    unique case (act)
      SU_REINDEX: begin
        mask_d = '0;
        mask_d[MASK_W-1]  = 1'b1;
        mask_d[IDX_W-1:0] = hit_idx;
      end
      SU_ALLOC: begin
        wen_d  = 1'b1;
        off_d  = free_off;
        mask_d = '0;
        mask_d[OFF_W-1:0] = free_off;
        occ_d  = occ_taken;
      end
      SU_INPLACE: begin
        wen_d = 1'b1;
      end
      SU_OVERFLOW: begin
        ovf_d = 1'b1;
      end
      default: begin
        ovf_d = 1'b0;
      end
    endcase
  end

  // registers: control always loaded, payload under clock enable
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      wen_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ovf_q  <= ovf_d;
      wen_q  <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      off_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      occ_q  <= '0;
    end else if (upd_en) begin
      off_q  <= off_d;
      data_q <= data_d;
      mask_q <= mask_d;
      occ_q  <= occ_d;
    end
  end

  assign done     = done_q;
  assign ovf      = ovf_q;
  assign dwr_en   = wen_q;
  assign dwr_off  = off_q;
  assign dwr_data = data_q;
  assign mask_out = mask_q;
  assign occ_out  = occ_q;
endmodule

// File: rtl/cc_store_update_chk.sv
module cc_store_update_chk #(
  parameter int MASK_W     = 4,
  parameter int META_W     = 3,
  parameter int OFF_W      = 3,
  parameter int SLOT_WORDS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  st_valid,
  input logic [MASK_W-1:0]     mask_in,
  input logic [SLOT_WORDS-1:0] occ_in,
  input logic                  done,
  input logic                  ovf,
  input logic                  dwr_en,
  input logic [OFF_W-1:0]      dwr_off,
  input logic [MASK_W-1:0]     mask_out,
  input logic [SLOT_WORDS-1:0] occ_out
);
  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> done);
  a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !done);
  a_r1_side_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_en || ovf) |-> done);
  a_r4_no_overflow_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (!dwr_en && occ_out == $past(occ_in) && mask_out == $past(mask_in)
             && $past(mask_in[MASK_W-1]) && ($past(occ_in) == {SLOT_WORDS{1'b1}})));
  a_r2_reindex_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mask_out[MASK_W-1] && !ovf) |-> (!dwr_en && occ_out == $past(occ_in)));
  a_r3_alloc_was_free: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dwr_en && $past(mask_in[MASK_W-1])) |->
      ((($past(occ_in) >> dwr_off) & SLOT_WORDS'(1)) == '0 &&
       $countones(occ_out) == $countones($past(occ_in)) + 1 &&
       !mask_out[MASK_W-1]));
  a_r5_raw_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(mask_in[MASK_W-1])) |->
      (dwr_en && !ovf && mask_out == $past(mask_in) && occ_out == $past(occ_in)
       && dwr_off == $past(mask_in[OFF_W-1:0])));
  a_r6_never_recompress: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(mask_in[MASK_W-1])) |-> !mask_out[MASK_W-1]);
endmodule

bind cc_store_update cc_store_update_chk #(
  .MASK_W(MASK_W), .META_W(META_W), .OFF_W(OFF_W), .SLOT_WORDS(SLOT_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_s), .st_valid(st_valid), .mask_in(mask_in), .occ_in(occ_in),
  .done(done), .ovf(ovf), .dwr_en(dwr_en), .dwr_off(dwr_off),
  .mask_out(mask_out), .occ_out(occ_out)
);

// File: tb/sim_cc_store_update.sv
`timescale 1ns/1ps
module sim_cc_store_update;
  localparam int WORD_W = 32, DICT_DEPTH = 8, SLOT_WORDS = 8;
  localparam int OFF_W = 3, IDX_W = 3, MASK_W = 4, BE_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid;
  logic [WORD_W-1:0] st_data, slot_word;
  logic [BE_W-1:0] st_be;
  logic [MASK_W-1:0] mask_in;
  logic [SLOT_WORDS-1:0] occ_in;
  logic [DICT_DEPTH*WORD_W-1:0] dict_flat;
  logic done, ovf, dwr_en;
  logic [OFF_W-1:0] dwr_off;
  logic [WORD_W-1:0] dwr_data;
  logic [MASK_W-1:0] mask_out;
  logic [SLOT_WORDS-1:0] occ_out;

  logic [WORD_W-1:0] dict [DICT_DEPTH];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cc_store_update u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_data(st_data), .st_be(st_be),
    .mask_in(mask_in), .occ_in(occ_in), .slot_word(slot_word), .dict_flat(dict_flat),
    .done(done), .ovf(ovf), .dwr_en(dwr_en), .dwr_off(dwr_off), .dwr_data(dwr_data),
    .mask_out(mask_out), .occ_out(occ_out)
  );

  // expected values from the requirements
  logic e_ovf, e_wen;
  logic [OFF_W-1:0] e_off;
  logic [WORD_W-1:0] e_data;
  logic [MASK_W-1:0] e_mask;
  logic [SLOT_WORDS-1:0] e_occ;

  function automatic logic [WORD_W-1:0] merge_val(input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] d, input logic [BE_W-1:0] be);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < BE_W; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : cur[i*8 +: 8];
    return r;
  endfunction

  task automatic compute_exp();
    logic [WORD_W-1:0] cur, m;
    int hit_at, free_at;
    cur = mask_in[3] ? dict[mask_in[2:0]] : slot_word;
    m = merge_val(cur, st_data, st_be);
    hit_at = -1;
    for (int j = DICT_DEPTH - 1; j >= 0; j--) if (dict[j] == m) hit_at = j;
    free_at = -1;
    for (int k = SLOT_WORDS - 1; k >= 0; k--) if (!occ_in[k]) free_at = k;
    e_ovf = 1'b0; e_wen = 1'b0; e_off = '0; e_data = m; e_mask = mask_in; e_occ = occ_in;
    if (!mask_in[3]) begin
      e_wen = 1'b1; e_off = mask_in[2:0];
    end else if (hit_at >= 0) begin
      e_mask = {1'b1, 3'(hit_at)};
    end else if (free_at >= 0) begin
      e_wen = 1'b1; e_off = 3'(free_at); e_mask = {1'b0, 3'(free_at)};
      e_occ = occ_in | (SLOT_WORDS'(1) << free_at);
    end else begin
      e_ovf = 1'b1;
    end
  endtask

  task automatic apply(input string tag, input logic [MASK_W-1:0] mk,
      input logic [SLOT_WORDS-1:0] oc, input logic [WORD_W-1:0] d,
      input logic [BE_W-1:0] be, input logic [WORD_W-1:0] sw);
    logic ok;
    @(negedge clk);
    mask_in = mk; occ_in = oc; st_data = d; st_be = be; slot_word = sw; st_valid = 1'b1;
    compute_exp();
    @(negedge clk);
    st_valid = 1'b0;
    ok = done && (ovf == e_ovf) && (dwr_en == e_wen) && (mask_out == e_mask) &&
         (occ_out == e_occ) && (!e_wen || (dwr_off == e_off && dwr_data == e_data));
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got done=%b ovf=%b wen=%b off=%0d data=%h mask=%h occ=%h exp ovf=%b wen=%b off=%0d data=%h mask=%h occ=%h",
        tag, done, ovf, dwr_en, dwr_off, dwr_data, mask_out, occ_out,
        e_ovf, e_wen, e_off, e_data, e_mask, e_occ);
    end
    @(negedge clk);
    n_chk++;
    if (done || dwr_en || ovf) begin
      n_fail++;
      $display("FAIL R1: got done=%b wen=%b ovf=%b exp 0 0 0", done, dwr_en, ovf);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    dict[0] = 32'h0000_0000; dict[1] = 32'h0000_0001; dict[2] = 32'hFFFF_FFFF;
    dict[3] = 32'h0000_0100; dict[4] = 32'h8000_0000; dict[5] = 32'h0000_FFFF;
    dict[6] = 32'h0000_0100; dict[7] = 32'h7FFF_FFFF;
    for (int j = 0; j < DICT_DEPTH; j++) dict_flat[j*WORD_W +: WORD_W] = dict[j];
    st_valid = 0; st_data = 0; st_be = 0; mask_in = 0; occ_in = 0; slot_word = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    n_chk++;
    if (done || ovf || dwr_en || mask_out != 0 || occ_out != 0) begin
      n_fail++;
      $display("FAIL R8: got done=%b ovf=%b wen=%b mask=%h occ=%h exp all zero",
        done, ovf, dwr_en, mask_out, occ_out);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (done) begin
      n_fail++;
      $display("FAIL R1: got done=%b exp 0 while idle", done);
    end

    apply("R2", 4'b1_010, 8'h0F, dict[5], 4'hF, 32'h0);
    apply("R2 lowest index", 4'b1_000, 8'h00, 32'h0000_0100, 4'hF, 32'h0);
    apply("R3", 4'b1_001, 8'b0000_1011, 32'h1234_5678, 4'hF, 32'h0);
    apply("R3 top word", 4'b1_001, 8'h7F, 32'hCAFE_0001, 4'hF, 32'h0);
    apply("R4", 4'b1_100, 8'hFF, 32'h1234_5678, 4'hF, 32'h0);
    apply("R5", 4'b0_011, 8'h08, 32'h5555_AAAA, 4'hF, 32'h1111_1111);
    apply("R6", 4'b0_101, 8'h20, dict[2], 4'hF, 32'h0);
    apply("R7 encoded merge", 4'b1_000, 8'h01, 32'hAB00_0001, 4'b0001, 32'h0);
    apply("R7 raw merge", 4'b0_110, 8'h40, 32'h1122_3344, 4'b0110, 32'hAABB_CCDD);
    apply("R7 no bytes", 4'b1_100, 8'hFF, 32'h1234_5678, 4'b0000, 32'h0);

    for (int it = 0; it < 400; it++) begin
      logic [MASK_W-1:0] mk;
      logic [SLOT_WORDS-1:0] oc;
      logic [WORD_W-1:0] d;
      logic [BE_W-1:0] be;
      string tag;
      mk = 4'($urandom);
      oc = 8'($urandom);
      if (($urandom % 3) == 0) oc = 8'hFF;
      if (!mk[3]) oc[mk[2:0]] = 1'b1;
      d = ($urandom % 2) ? dict[$urandom % DICT_DEPTH] : $urandom;
      be = ($urandom % 2) ? 4'hF : 4'($urandom);
      if (!mk[3]) tag = "R5/R6 random raw";
      else tag = "R2/R3/R4/R7 random encoded";
      apply(tag, mk, oc, d, be, $urandom);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule